// File: doc/BRIEF.md
# Tagged Receive Queue for a Serial Receiver

This block sits between the character assembler of a serial receiver and the host-facing register file. Every character that arrives is written as one entry: the eight data bits plus three per-character error tags (parity, framing, break). The host pulls characters out through a holding-register read port. The line-status word it sees always describes the character currently waiting in that holding register, so the tags and the data never drift apart.

In queue mode the holding register is the output end of a 64-entry first-in, first-out store. In single mode the block holds exactly one unread character, as a plain holding register does. A character that arrives when no room is left is dropped and raises a sticky overrun flag. A status read clears that flag. Any change of the mode input empties the store.

Top module: `rx_tagged_queue`

## Requirements
- R1: During and straight after reset, `hold_data` is 0 and every bit of `line_status` is 0.
- R2: In queue mode (`fifo_en` = 1) up to 64 characters are held, and they leave in the order they arrived.
- R3: `hold_data` shows the oldest unread character. A `host_rd_data` pulse while a character is waiting removes it, and the next one appears after that clock edge.
- R4: `line_status[2]`, `[3]` and `[4]` carry the parity, framing and break tags that were written with the character now shown on `hold_data`. They are 0 when nothing is waiting.
- R5: `line_status[0]` (data ready) is 1 exactly when at least one unread character is held.
- R6: A character that arrives while the store is at capacity, with no read in the same cycle, is discarded and sets `line_status[1]` (overrun) after that edge.
- R7: A `host_rd_status` pulse clears overrun after that edge. If a discard happens in the same cycle, the flag is set instead.
- R8: In single mode (`fifo_en` = 0) the capacity is one character. A second arrival before the read is discarded with overrun.
- R9: A `host_rd_data` pulse while nothing is waiting leaves `hold_data` at the last character read, leaves data ready at 0, and does not disturb the order of later arrivals.
- R10: In a cycle where `fifo_en` differs from its value in the previous cycle (the value is taken as 0 after reset), the store is emptied. Writes and reads in that cycle are ignored.
- R11: When the store is at capacity and a read and an arrival happen in the same cycle, both take effect and overrun is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single mode |
| rx_valid | input | 1 | One-cycle strobe: a character is offered |
| rx_byte | input | 8 | Data of the offered character |
| rx_parity_err | input | 1 | Parity tag of the offered character |
| rx_frame_err | input | 1 | Framing tag of the offered character |
| rx_break | input | 1 | Break tag of the offered character |
| host_rd_data | input | 1 | Host reads the holding register this cycle |
| host_rd_status | input | 1 | Host reads the line-status word this cycle |
| hold_data | output | 8 | Character presented to the host |
| line_status | output | 5 | {break, framing, parity, overrun, data ready} |

## Verification
The case that is hardest to reach from the ports is a full 64-entry store that then sees an arrival together with a read, and an overrun discard together with a status read. Random traffic with balanced rates almost never fills the queue. The stimulus therefore runs a directed fill of exactly 64 characters, then drives these coincident strobes on purpose. After that comes a random phase whose write rate is much higher than its read rate, so it returns to the full boundary many times. Occasional mode toggles in the random phase exercise emptying a partly filled store.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  localparam int BYTE_W = 8;
  localparam int LSR_W  = 5;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_tag_t;

  typedef struct packed {
    rxq_tag_t             tag;
    logic [BYTE_W-1:0]    data;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);

  // Number of characters the store may hold in the selected mode.
  function automatic int unsigned rxq_cap(input logic queue_mode, input int unsigned depth);
    return queue_mode ? depth : 32'd1;
  endfunction

  // Line-status word: {brk, frm, par, overrun, ready}; tags shown only while ready.
  function automatic logic [LSR_W-1:0] rxq_lsr(input logic ready, input logic ovr, input rxq_tag_t t);
    logic [2:0] shown;
    shown = ready ? {t.brk, t.frm, t.par} : 3'b000;
    return {shown, ovr, ready};
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             wr_valid,
  input  logic             rd_req,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             push,
  output logic             pop,
  output logic             ovr_evt,
  output logic             empty,
  output logic             mode_flip
);
  import rxq_pkg::*;

  logic             en_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cap_w;
  logic             full;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign cap_w     = CNT_W'(rxq_cap(fifo_en, DEPTH));
  assign mode_flip = fifo_en ^ en_q;
  assign empty     = (count_q == '0);
  assign full      = (count_q >= cap_w);
  assign pop       = rd_req && !empty && !mode_flip;
  assign push      = wr_valid && !mode_flip && (!full || pop);
  assign ovr_evt   = wr_valid && !mode_flip && !push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      count_q <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
    end else begin
      en_q <= fifo_en;
      if (mode_flip) begin
        count_q <= '0;
        wr_ptr  <= '0;
        rd_ptr  <= '0;
      end else begin
        if (push) wr_ptr <= ptr_inc(wr_ptr);
        if (pop)  rd_ptr <= ptr_inc(rd_ptr);
        count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
      end
    end
  end

  // R2 / R8: occupancy never exceeds the capacity of the current mode
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_flip |-> (count_q <= cap_w));

  // R10: a mode change leaves the store empty
  a_r10_flip_empties: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> empty);

  // R3: a read of a waiting character moves the read side
  a_r3_pop_moves: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (rd_ptr != $past(rd_ptr)));

  // R9: reading an empty store moves nothing
  a_r9_empty_read_still: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !mode_flip) |=> $stable(rd_ptr));

  // R11: a full store with a read accepts the arrival
  a_r11_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_req && !empty && !mode_flip) |-> !ovr_evt);

endmodule

// File: rtl/rxq_mem.sv
`timescale 1ns/1ps
module rxq_mem #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [PTR_W-1:0]    waddr,
  input  rxq_pkg::rxq_entry_t wentry,
  input  logic [PTR_W-1:0]    raddr,
  output rxq_pkg::rxq_entry_t rentry
);
  import rxq_pkg::*;

  rxq_entry_t       slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign slot_we[i] = we && (waddr == PTR_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wentry;
    end
  end

  assign rentry = slot_q[raddr];

  // R2: at most one slot written per cycle
  a_r2_one_slot: assert property (@(posedge clk) $onehot0(slot_we));

endmodule

// File: rtl/rxq_status.sv
`timescale 1ns/1ps
module rxq_status (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pop,
  input  logic                            empty,
  input  logic                            ovr_evt,
  input  logic                            stat_rd,
  input  rxq_pkg::rxq_entry_t             head,
  output logic [rxq_pkg::BYTE_W-1:0]      hold_data,
  output logic [rxq_pkg::LSR_W-1:0]       line_status
);
  import rxq_pkg::*;

  logic [BYTE_W-1:0] last_q;
  logic              ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (pop) last_q <= head.data;
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
    end
  end

  assign hold_data   = empty ? last_q : head.data;
  assign line_status = rxq_lsr(!empty, ovr_q, head.tag);

  // R6: a discarded arrival raises overrun
  a_r6_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> line_status[1]);

  // R7: a status read without a discard clears overrun
  a_r7_ovr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !line_status[1]);

  // R9: while nothing waits, the presented character does not change
  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(empty) && empty) |-> $stable(hold_data));

  // R4: tags are hidden when nothing waits
  a_r4_tags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (line_status[4:2] == 3'b000));

endmodule

// File: rtl/rx_tagged_queue.sv
`timescale 1ns/1ps
module rx_tagged_queue #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic                       rx_valid,
  input  logic [rxq_pkg::BYTE_W-1:0] rx_byte,
  input  logic                       rx_parity_err,
  input  logic                       rx_frame_err,
  input  logic                       rx_break,
  input  logic                       host_rd_data,
  input  logic                       host_rd_status,
  output logic [rxq_pkg::BYTE_W-1:0] hold_data,
  output logic [rxq_pkg::LSR_W-1:0]  line_status
);
  import rxq_pkg::*;

  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             push_evt;
  logic             pop_evt;
  logic             ovr_evt;
  logic             empty;
  logic             mode_flip;
  rxq_entry_t       in_entry;
  rxq_entry_t       head_entry;

  assign in_entry.data    = rx_byte;
  assign in_entry.tag.par = rx_parity_err;
  assign in_entry.tag.frm = rx_frame_err;
  assign in_entry.tag.brk = rx_break;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .wr_valid  (rx_valid),
    .rd_req    (host_rd_data),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .push      (push_evt),
    .pop       (pop_evt),
    .ovr_evt   (ovr_evt),
    .empty     (empty),
    .mode_flip (mode_flip)
  );

  rxq_mem #(.DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .we     (push_evt),
    .waddr  (wr_ptr),
    .wentry (in_entry),
    .raddr  (rd_ptr),
    .rentry (head_entry)
  );

  rxq_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop         (pop_evt),
    .empty       (empty),
    .ovr_evt     (ovr_evt),
    .stat_rd     (host_rd_status),
    .head        (head_entry),
    .hold_data   (hold_data),
    .line_status (line_status)
  );

  // R5: data ready follows occupancy one edge after a push into an empty store
  a_r5_ready_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !pop_evt) |=> line_status[0]);

  // R10: nothing is stored or taken in a mode-change cycle
  a_r10_flip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |-> (!push_evt && !pop_evt && !ovr_evt));

endmodule

// File: tb/sim_rx_tagged_queue.sv
`timescale 1ns/1ps
module sim_rx_tagged_queue;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       rx_parity_err;
  logic       rx_frame_err;
  logic       rx_break;
  logic       host_rd_data;
  logic       host_rd_status;
  logic [7:0] hold_data;
  logic [4:0] line_status;

  always #4 clk = ~clk;

  rx_tagged_queue u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_en        (fifo_en),
    .rx_valid       (rx_valid),
    .rx_byte        (rx_byte),
    .rx_parity_err  (rx_parity_err),
    .rx_frame_err   (rx_frame_err),
    .rx_break       (rx_break),
    .host_rd_data   (host_rd_data),
    .host_rd_status (host_rd_status),
    .hold_data      (hold_data),
    .line_status    (line_status)
  );

  // reference model: entry = {brk, frm, par, data}
  logic [10:0] mq[$];
  logic        m_ovr;
  logic [7:0]  m_last;
  logic        m_en_prev;
  int          pass_n = 0;
  int          fail_n = 0;
  bit          done = 0;

  function automatic logic [7:0] exp_hold();
    return (mq.size() != 0) ? mq[0][7:0] : m_last;
  endfunction

  function automatic logic [4:0] exp_status();
    if (mq.size() != 0) return {mq[0][10:8], m_ovr, 1'b1};
    return {3'b000, m_ovr, 1'b0};
  endfunction

  task automatic check_out(input string tag);
    logic [7:0] eh;
    logic [4:0] es;
    eh = exp_hold();
    es = exp_status();
    if (hold_data === eh) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s hold_data actual=%02h expected=%02h", tag, hold_data, eh);
    end
    if (line_status === es) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s line_status actual=%05b expected=%05b", tag, line_status, es);
    end
  endtask

  // one clock: check state at negedge, drive inputs, advance the model
  task automatic cyc(input bit en, input bit wv, input logic [7:0] d, input logic [2:0] t,
                     input bit rd, input bit srd, input string tag);
    int  cap;
    bit  pop, full, acc;
    @(negedge clk);
    check_out(tag);
    fifo_en        = en;
    rx_valid       = wv;
    rx_byte        = d;
    rx_break       = t[2];
    rx_frame_err   = t[1];
    rx_parity_err  = t[0];
    host_rd_data   = rd;
    host_rd_status = srd;
    if (en != m_en_prev) begin
      mq.delete();
      m_en_prev = en;
      if (srd) m_ovr = 1'b0;
    end else begin
      cap  = en ? 64 : 1;
      pop  = rd && (mq.size() > 0);
      full = (mq.size() >= cap);
      acc  = wv && (!full || pop);
      if (pop) begin
        m_last = mq[0][7:0];
        void'(mq.pop_front());
      end
      if (acc) mq.push_back({t, d});
      if (wv && !acc) m_ovr = 1'b1;
      else if (srd)   m_ovr = 1'b0;
    end
  endtask

  task automatic idle(input bit en, input string tag);
    cyc(en, 0, 8'h00, 3'b000, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail_n++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 0; fifo_en = 1; rx_valid = 0; rx_byte = 0;
    rx_parity_err = 0; rx_frame_err = 0; rx_break = 0;
    host_rd_data = 0; host_rd_status = 0;
    m_ovr = 0; m_last = 0; m_en_prev = 0;
    repeat (2) begin
      @(negedge clk);
      check_out("R1");
    end
    @(negedge clk);
    rst_n = 1;

    // R10: first cycle after reset is a mode change to queue mode
    idle(1, "R10");
    idle(1, "R1");

    // R2 R3 R4 R5: three characters with distinct tags, then read back
    cyc(1, 1, 8'hA5, 3'b001, 0, 0, "R4");
    cyc(1, 1, 8'h3C, 3'b010, 0, 0, "R4");
    cyc(1, 1, 8'h7E, 3'b100, 0, 0, "R4");
    idle(1, "R5");
    cyc(1, 0, 8'h00, 3'b000, 1, 0, "R3");
    cyc(1, 0, 8'h00, 3'b000, 1, 0, "R4");
    cyc(1, 0, 8'h00, 3'b000, 1, 0, "R2");
    idle(1, "R5");

    // R9: reads of an empty store
    cyc(1, 0, 8'h00, 3'b000, 1, 0, "R9");
    cyc(1, 0, 8'h00, 3'b000, 1, 0, "R9");
    cyc(1, 1, 8'h11, 3'b011, 0, 0, "R9");
    cyc(1, 0, 8'h00, 3'b000, 1, 0, "R9");
    idle(1, "R9");

    // R2 R6: fill to 64, then one more
    for (int i = 0; i < 64; i++) cyc(1, 1, 8'(i + 8'h40), 3'(i % 8), 0, 0, "R2");
    idle(1, "R2");
    cyc(1, 1, 8'hEE, 3'b111, 0, 0, "R6");
    idle(1, "R6");
    // R11: full, read and arrival together
    cyc(1, 1, 8'hD1, 3'b101, 1, 0, "R11");
    idle(1, "R11");
    // R7: status read clears; discard plus status read keeps it set
    cyc(1, 0, 8'h00, 3'b000, 0, 1, "R7");
    idle(1, "R7");
    cyc(1, 1, 8'hBB, 3'b000, 0, 1, "R7");
    idle(1, "R7");
    cyc(1, 0, 8'h00, 3'b000, 0, 1, "R7");
    // drain part of it
    for (int i = 0; i < 20; i++) cyc(1, 0, 8'h00, 3'b000, 1, 0, "R3");

    // R10: mode change with data held, with a write and read in the same cycle
    cyc(0, 1, 8'h99, 3'b111, 1, 0, "R10");
    idle(0, "R10");
    // R8: single mode
    cyc(0, 1, 8'h21, 3'b010, 0, 0, "R8");
    cyc(0, 1, 8'h22, 3'b001, 0, 0, "R8");
    idle(0, "R8");
    cyc(0, 1, 8'h23, 3'b100, 1, 1, "R8");
    idle(0, "R8");
    cyc(0, 0, 8'h00, 3'b000, 1, 0, "R8");
    idle(0, "R8");
    cyc(1, 1, 8'h55, 3'b000, 0, 0, "R10");
    idle(1, "R10");

    // random traffic, write-heavy and balanced phases, occasional mode toggles
    begin
      bit en_r;
      en_r = 1;
      for (int n = 0; n < 4000; n++) begin
        int wp;
        wp = ((n / 500) % 2 == 0) ? 90 : 45;
        if (($urandom % 400) == 0) en_r = ~en_r;
        cyc(en_r, (($urandom % 100) < wp), 8'($urandom), 3'($urandom),
            (($urandom % 100) < 40), (($urandom % 100) < 8), "R2");
      end
    end
    idle(1, "R10");
    idle(1, "R5");
    @(negedge clk);
    check_out("R3");
    finish_run();
  end

endmodule